// File: doc/BRIEF.md
# Gap-Smoothing Output Clock Generator

This block sits after a frame decoder. The decoder hands over only the data bytes of each frame: 188 of them in every 204 byte times, each written with a single-cycle valid strobe. The first byte of a frame carries a sync tag. The block queues the bytes in a small FIFO and presents them downstream with an output clock. The output clock is a signal in the system clock domain, driven high and low on chosen cycles. It is not a separate clock tree.

A fixed internal slot timer splits time into byte slots of `SLOT_CYCLES` system clocks. There are two pacing modes:

- **Gap mode:** once a sync-tagged byte reaches the FIFO head, the block clocks out 188 bytes, one per slot with no break. The clock then stays low until the next sync byte arrives.
- **Smooth mode:** a fractional accumulator adds 188 on every slot and releases a byte whenever the sum reaches 204, then subtracts 204. The missing 16 slots are therefore spread across the frame.

The output is either a parallel byte with a byte-rate clock or a serial stream with a bit-rate clock. In serial mode the bit order can be chosen. A frame-start output marks the first byte, or the first bit, of each frame.

Top module: `smooth_out_clkgen`

## Requirements
- R1: After reset, `out_clk`, `out_sof` and `ovf_flag` are low, and no output clock edge occurs until a sync-tagged byte has been written.
- R2: Bytes that reach the FIFO head while no frame is open, and that carry no sync tag, are discarded and never clocked out.
- R3: A write that arrives while the FIFO already holds `FIFO_DEPTH` entries is dropped and sets `ovf_flag`. The flag stays high until reset. Smooth mode under nominal input never sets it.
- R4: In gap mode (`pace_smooth`=0), a sync byte at the head starts a run of exactly 188 bytes in consecutive slots. Bytes after the run that carry no sync tag produce no clock.
- R5: In smooth mode (`pace_smooth`=1), consecutive bytes are one or two slots apart. Exactly 188 bytes are released in every 204 slots.
- R6: Output bytes appear in the same order and with the same values as the bytes written.
- R7: In parallel mode (`ser_en`=0), each byte period lasts `SLOT_CYCLES` clocks. `out_clk` is low for the first half and high for the second half, and `out_data` is stable for the whole period.
- R8: In serial mode (`ser_en`=1), each byte period carries 8 bit periods of `SLOT_CYCLES`/8 clocks each. `out_clk` is low for the first half and high for the second half of each bit period, and `out_bit` is valid while the clock is high.
- R9: In serial mode, `lsb_first`=1 sends data bit 0 first and bit 7 last. `lsb_first`=0 sends bit 7 first and bit 0 last.
- R10: `out_sof` is high during the whole first byte period (parallel) or the whole first bit period (serial) of a sync-tagged byte, and low at all other times.
- R11: In a slot that carries no byte, `out_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pace_smooth | input | 1 | 0: gap pacing, 1: smooth fractional pacing |
| ser_en | input | 1 | 0: parallel byte output, 1: serial bit output |
| lsb_first | input | 1 | Serial bit order: 1 sends bit 0 first |
| in_valid | input | 1 | Input byte strobe, one cycle per byte |
| in_data | input | 8 | Input data byte |
| in_sof | input | 1 | Tags the input byte as the first byte of a frame |
| out_clk | output | 1 | Output clock, byte rate or bit rate |
| out_data | output | 8 | Parallel output byte |
| out_bit | output | 1 | Serial output bit |
| out_sof | output | 1 | Frame-start marker for the first byte or bit |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench measures the spacing between output clock edges, not only the byte values.

- **Gap mode:** the bench checks that the gap between frame runs is exactly 17 slots. A run counter that is off by one would shorten or extend this interval and would leak trailing bytes.
- **Smooth mode:** the bench checks that byte 188 lands exactly 204 slots after byte 0, and that no two empty slots ever occur in a row. An accumulator with a wrong compare or wrong subtraction would drift off that span, or would bunch its gaps together.
- **Serial mode:** the bench sends asymmetric bytes in both bit orders, so a reversed bit index shows up as corrupted data.
- **Untagged bytes and overflow:** the bench writes untagged bytes before a frame and overruns the FIFO. A block that kept stray bytes would clock them out, and a block whose flag was not sticky would drop `ovf_flag` once the FIFO drained.

// File: rtl/smooth_out_pkg.sv
package smooth_out_pkg;

    localparam int BYTE_W = 8;

    // One queued byte together with its frame-start tag
    typedef struct packed {
        logic              sof;
        logic [BYTE_W-1:0] data;
    } ob_entry_t;

    typedef enum logic {
        MODE_GAP    = 1'b0,
        MODE_SMOOTH = 1'b1
    } pace_mode_e;

    // Serial bit selection for a given bit slot and ordering
    function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                      input logic [2:0]        idx,
                                      input logic              lsb_first);
        logic [2:0] sel;
        sel = lsb_first ? idx : (3'd7 - idx);
        return b[sel];
    endfunction

endpackage

// File: rtl/smooth_out_fifo.sv
module smooth_out_fifo
    import smooth_out_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ob_entry_t        wr_entry,
    input  logic             rd_en,
    output ob_entry_t        rd_entry,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level,
    output logic             ovf_flag
);

    ob_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push;

    assign empty    = (level == '0);
    assign full     = (level == LVL_W'(DEPTH));
    assign push     = wr_en && !full;
    assign rd_entry = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            case ({push, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (wr_en && full) begin
                ovf_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/smooth_out_pacer.sv
module smooth_out_pacer
    import smooth_out_pkg::*;
#(
    parameter int SLOT_CYCLES = 16,
    parameter int FRAME_DATA  = 188,
    parameter int FRAME_SLOTS = 204,
    localparam int SC_W  = $clog2(SLOT_CYCLES),
    localparam int ACC_W = $clog2(FRAME_SLOTS + FRAME_DATA) + 1,
    localparam int RUN_W = $clog2(FRAME_DATA + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  pace_mode_e      mode,
    input  ob_entry_t       head,
    input  logic            empty,
    output logic            pop,
    output logic            go,
    output logic            slot_end,
    output logic [SC_W-1:0] phase
);

    logic [SC_W-1:0]  sc;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic             hit;
    logic [RUN_W-1:0] run_cnt;
    logic             locked;
    logic             armed;
    logic             drop;

    assign phase    = sc;
    assign slot_end = (sc == SC_W'(SLOT_CYCLES - 1));
    assign acc_sum  = acc + ACC_W'(FRAME_DATA);
    assign hit      = (acc_sum >= ACC_W'(FRAME_SLOTS));

    always_comb begin
        if (mode == MODE_SMOOTH) begin
            armed = locked;
            go    = slot_end && hit && !empty && (locked || head.sof);
        end else begin
            armed = (run_cnt != '0);
            go    = slot_end && !empty && (armed || head.sof);
        end
        // untagged bytes outside an open frame are flushed at once
        drop = !empty && !head.sof && !armed;
        pop  = go || drop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc <= '0;
        end else if (slot_end) begin
            sc <= '0;
        end else begin
            sc <= sc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (slot_end) begin
            acc <= hit ? (acc_sum - ACC_W'(FRAME_SLOTS)) : acc_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            locked  <= 1'b0;
        end else if (mode == MODE_SMOOTH) begin
            run_cnt <= '0;
            if (go && head.sof) begin
                locked <= 1'b1;
            end
        end else begin
            locked <= 1'b0;
            if (go) begin
                run_cnt <= armed ? (run_cnt - 1'b1) : RUN_W'(FRAME_DATA - 1);
            end
        end
    end

endmodule

// File: rtl/smooth_out_fmt.sv
module smooth_out_fmt
    import smooth_out_pkg::*;
#(
    parameter int SLOT_CYCLES = 16,
    localparam int SC_W     = $clog2(SLOT_CYCLES),
    localparam int HALF     = SLOT_CYCLES / 2,
    localparam int BIT_CYC  = SLOT_CYCLES / 8,
    localparam int BIT_HALF = BIT_CYC / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_end,
    input  logic              load,
    input  ob_entry_t         load_entry,
    input  logic [SC_W-1:0]   phase,
    input  logic              ser_en,
    input  logic              lsb_first,
    output logic              out_clk,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_bit,
    output logic              out_sof
);

    ob_entry_t       cur;
    logic            busy;
    logic [2:0]      bidx;
    logic [SC_W-1:0] sub;
    logic            par_clk;
    logic            ser_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (slot_end) begin
            busy <= load;
            if (load) begin
                cur <= load_entry;
            end
        end
    end

    assign bidx    = 3'(phase / SC_W'(BIT_CYC));
    assign sub     = phase % SC_W'(BIT_CYC);
    assign par_clk = busy && (phase >= SC_W'(HALF));
    assign ser_clk = busy && (sub >= SC_W'(BIT_HALF));

    always_comb begin
        out_data = cur.data;
        if (ser_en) begin
            out_clk = ser_clk;
            out_bit = busy && pick_bit(cur.data, bidx, lsb_first);
            out_sof = busy && cur.sof && (bidx == 3'd0);
        end else begin
            out_clk = par_clk;
            out_bit = 1'b0;
            out_sof = busy && cur.sof;
        end
    end

endmodule

// File: rtl/smooth_out_clkgen.sv
module smooth_out_clkgen
    import smooth_out_pkg::*;
#(
    parameter int SLOT_CYCLES = 16,
    parameter int FRAME_DATA  = 188,
    parameter int FRAME_SLOTS = 204,
    parameter int FIFO_DEPTH  = 32,
    localparam int SC_W  = $clog2(SLOT_CYCLES),
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pace_smooth,
    input  logic       ser_en,
    input  logic       lsb_first,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    output logic       out_clk,
    output logic [7:0] out_data,
    output logic       out_bit,
    output logic       out_sof,
    output logic       ovf_flag
);

    ob_entry_t        wr_entry;
    ob_entry_t        head;
    logic             fifo_empty;
    logic             fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_pop;
    logic             byte_go;
    logic             slot_end;
    logic [SC_W-1:0]  phase;
    pace_mode_e       mode;

    assign wr_entry = '{sof: in_sof, data: in_data};
    assign mode     = pace_smooth ? MODE_SMOOTH : MODE_GAP;

    smooth_out_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (in_valid),
        .wr_entry (wr_entry),
        .rd_en    (fifo_pop),
        .rd_entry (head),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .level    (fifo_level),
        .ovf_flag (ovf_flag)
    );

    smooth_out_pacer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .FRAME_DATA  (FRAME_DATA),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .head     (head),
        .empty    (fifo_empty),
        .pop      (fifo_pop),
        .go       (byte_go),
        .slot_end (slot_end),
        .phase    (phase)
    );

    smooth_out_fmt #(.SLOT_CYCLES(SLOT_CYCLES)) u_fmt (
        .clk        (clk),
        .rst        (rst),
        .slot_end   (slot_end),
        .load       (byte_go),
        .load_entry (head),
        .phase      (phase),
        .ser_en     (ser_en),
        .lsb_first  (lsb_first),
        .out_clk    (out_clk),
        .out_data   (out_data),
        .out_bit    (out_bit),
        .out_sof    (out_sof)
    );

endmodule

// File: rtl/smooth_out_chk.sv
module smooth_out_chk #(
    parameter int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_en,
    input logic             out_clk,
    input logic [7:0]       out_data,
    input logic             out_sof,
    input logic             ovf_flag,
    input logic             pop,
    input logic             empty,
    input logic [LVL_W-1:0] level
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_clk && !out_sof && !ovf_flag));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    p_par_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ser_en && !$past(ser_en) && out_clk && $past(out_clk)) |-> $stable(out_data));

    p_sof_starts_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(out_sof) |-> !out_clk);

endmodule

bind smooth_out_clkgen smooth_out_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_en   (ser_en),
    .out_clk  (out_clk),
    .out_data (out_data),
    .out_sof  (out_sof),
    .ovf_flag (ovf_flag),
    .pop      (fifo_pop),
    .empty    (fifo_empty),
    .level    (fifo_level)
);

// File: tb/smooth_out_clkgen_bench.sv
module smooth_out_clkgen_bench;

    localparam int CLK_P = 10;
    localparam int SLOT  = 16;
    localparam int FDATA = 188;
    localparam int FSLOT = 204;
    localparam int DEPTH = 32;
    localparam int CAPN  = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pace_smooth = 1'b0;
    logic       ser_en = 1'b0;
    logic       lsb_first = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       out_clk;
    logic [7:0] out_data;
    logic       out_bit;
    logic       out_sof;
    logic       ovf_flag;

    always #(CLK_P / 2) clk = ~clk;

    smooth_out_clkgen u_smooth_out_clkgen (
        .clk         (clk),
        .rst         (rst),
        .pace_smooth (pace_smooth),
        .ser_en      (ser_en),
        .lsb_first   (lsb_first),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_sof      (in_sof),
        .out_clk     (out_clk),
        .out_data    (out_data),
        .out_bit     (out_bit),
        .out_sof     (out_sof),
        .ovf_flag    (ovf_flag)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- output monitor ----------------
    logic [7:0] cap     [CAPN];
    logic       cap_sof [CAPN];
    longint     rt      [CAPN];
    int         ncap;
    int         duty_err;
    int         hold_err;
    int         sof_err;
    int         hi_cnt;
    int         bitcnt;
    logic       prev_clk;
    logic [7:0] pdata;
    logic [7:0] asm_b;
    logic       asm_sof;

    always @(negedge clk) begin
        if (rst) begin
            ncap = 0; duty_err = 0; hold_err = 0; sof_err = 0;
            hi_cnt = 0; bitcnt = 0; prev_clk = 1'b0; pdata = '0;
            asm_b = '0; asm_sof = 1'b0;
        end else begin
            if (out_clk && !prev_clk) begin
                hi_cnt = 1;
                if (!ser_en) begin
                    if (ncap < CAPN) begin
                        cap[ncap] = out_data; cap_sof[ncap] = out_sof; rt[ncap] = cyc;
                    end
                    pdata = out_data;
                    ncap++;
                end else begin
                    if (bitcnt == 0) begin
                        asm_sof = out_sof;
                        if (ncap < CAPN) rt[ncap] = cyc;
                    end else if (out_sof) begin
                        sof_err++;
                    end
                    if (lsb_first) asm_b[bitcnt] = out_bit;
                    else asm_b[7 - bitcnt] = out_bit;
                    bitcnt++;
                    if (bitcnt == 8) begin
                        if (ncap < CAPN) begin
                            cap[ncap] = asm_b; cap_sof[ncap] = asm_sof;
                        end
                        ncap++;
                        bitcnt = 0;
                    end
                end
            end else if (out_clk) begin
                hi_cnt++;
                if (!ser_en && out_data != pdata) hold_err++;
            end else if (prev_clk) begin
                if (hi_cnt != (ser_en ? SLOT / 16 : SLOT / 2)) duty_err++;
            end
            prev_clk = out_clk;
        end
    end

    // ---------------- expected stream ----------------
    logic [7:0] exp_q [CAPN];
    int         nexp;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset(input bit smooth, input bit ser, input bit lsb);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0;
        pace_smooth = smooth; ser_en = ser; lsb_first = lsb;
        nexp = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic put_slot(input logic [7:0] d, input bit s);
        in_valid = 1'b1; in_data = d; in_sof = s;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        repeat (SLOT - 1) @(negedge clk);
    endtask

    task automatic send_frame(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'((base + i * 7) & 8'hff);
            put_slot(d, i == 0);
            exp_q[nexp] = d;
            nexp++;
        end
    endtask

    task automatic idle_slots(input int n);
        repeat (n * SLOT) @(negedge clk);
    endtask

    task automatic compare_stream(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < nexp && i < ncap; i++) begin
            if (cap[i] != exp_q[i]) bad++;
        end
        check(ncap == nexp, req, "byte count", ncap, nexp);
        check(bad == 0, req, "mismatching bytes", bad, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        do_reset(1'b0, 1'b0, 1'b0);
        check(out_clk == 1'b0, "R1", "out_clk after reset", out_clk, 0);
        check(out_sof == 1'b0, "R1", "out_sof after reset", out_sof, 0);
        check(ovf_flag == 1'b0, "R1", "ovf_flag after reset", ovf_flag, 0);
        idle_slots(12);
        check(ncap == 0, "R1", "clock edges with no input", ncap, 0);
    endtask

    task automatic t_discard;
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) put_slot(8'(8'hE0 + i), 1'b0);
        send_frame(16, 4);
        idle_slots(10);
        compare_stream("R2");
        check(cap_sof[0] == 1'b1, "R10", "sof on first byte", cap_sof[0], 1);
        check(cap_sof[1] == 1'b0 && cap_sof[3] == 1'b0, "R10", "sof on later byte",
              cap_sof[1], 0);
    endtask

    task automatic t_gap;
        int bad_iv;
        int bad_sof;
        do_reset(1'b0, 1'b0, 1'b0);
        send_frame(3, FDATA);
        idle_slots(FSLOT - FDATA);
        send_frame(91, FDATA);
        for (int i = 0; i < 5; i++) put_slot(8'(8'h55 + i), 1'b0);
        idle_slots(30);
        compare_stream("R4 R6");
        bad_iv = 0;
        for (int i = 1; i < 2 * FDATA; i++) begin
            if (i != FDATA && rt[i] - rt[i-1] != SLOT) bad_iv++;
        end
        check(bad_iv == 0, "R4", "run byte spacing errors", bad_iv, 0);
        check(rt[FDATA] - rt[FDATA-1] == 17 * SLOT, "R4", "inter-run interval",
              rt[FDATA] - rt[FDATA-1], 17 * SLOT);
        check(duty_err == 0, "R7", "parallel clock high-time errors", duty_err, 0);
        check(hold_err == 0, "R7", "out_data changes while clock high", hold_err, 0);
        bad_sof = 0;
        for (int i = 0; i < 2 * FDATA; i++) begin
            if (cap_sof[i] != (i == 0 || i == FDATA)) bad_sof++;
        end
        check(bad_sof == 0, "R10", "sof placement errors", bad_sof, 0);
        check(out_clk == 1'b0, "R11", "clock idle after runs", out_clk, 0);
    endtask

    task automatic t_smooth;
        int bad_iv;
        int dbl;
        do_reset(1'b1, 1'b0, 1'b0);
        for (int f = 0; f < 3; f++) begin
            send_frame(f * 40 + 1, FDATA);
            idle_slots(FSLOT - FDATA);
        end
        idle_slots(40);
        compare_stream("R5 R6");
        bad_iv = 0;
        dbl = 0;
        for (int i = 1; i < 3 * FDATA; i++) begin
            if (rt[i] - rt[i-1] != SLOT && rt[i] - rt[i-1] != 2 * SLOT) bad_iv++;
            if (i <= FDATA && rt[i] - rt[i-1] == 2 * SLOT) dbl++;
        end
        check(bad_iv == 0, "R5", "spacing not one or two slots", bad_iv, 0);
        check(rt[FDATA] - rt[0] == FSLOT * SLOT, "R5", "span of first 188 bytes",
              rt[FDATA] - rt[0], FSLOT * SLOT);
        check(rt[2*FDATA] - rt[FDATA] == FSLOT * SLOT, "R5", "span of second 188 bytes",
              rt[2*FDATA] - rt[FDATA], FSLOT * SLOT);
        check(dbl == FSLOT - FDATA, "R11", "empty slots per frame", dbl, FSLOT - FDATA);
        check(ovf_flag == 1'b0, "R3", "no overflow in smooth mode", ovf_flag, 0);
        check(cap_sof[FDATA] == 1'b1, "R10", "sof on second frame", cap_sof[FDATA], 1);
    endtask

    task automatic t_serial(input bit lsb, input string req);
        do_reset(1'b0, 1'b1, lsb);
        put_slot(8'h01, 1'b1); exp_q[0] = 8'h01;
        put_slot(8'h80, 1'b0); exp_q[1] = 8'h80;
        put_slot(8'hC5, 1'b0); exp_q[2] = 8'hC5;
        put_slot(8'h3A, 1'b0); exp_q[3] = 8'h3A;
        nexp = 4;
        idle_slots(6);
        compare_stream(req);
        check(duty_err == 0, "R8", "serial clock high-time errors", duty_err, 0);
        check(rt[1] - rt[0] == SLOT, "R8", "byte period in serial", rt[1] - rt[0], SLOT);
        check(sof_err == 0, "R10", "sof outside first bit", sof_err, 0);
        check(cap_sof[0] == 1'b1, "R10", "sof on first serial bit", cap_sof[0], 1);
    endtask

    task automatic t_ovf;
        int got;
        do_reset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 41; i++) begin
            in_valid = 1'b1; in_data = 8'(i); in_sof = (i == 0);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        check(ovf_flag == 1'b1, "R3", "flag after overrun", ovf_flag, 1);
        idle_slots(60);
        check(ovf_flag == 1'b1, "R3", "flag sticky after drain", ovf_flag, 1);
        got = ncap;
        check(got >= DEPTH && got < 41, "R3", "bytes delivered after overrun", got, DEPTH);
        do_reset(1'b0, 1'b0, 1'b0);
        check(ovf_flag == 1'b0, "R3", "flag cleared by reset", ovf_flag, 0);
    endtask

    initial begin
        t_reset();
        t_discard();
        t_gap();
        t_smooth();
        t_serial(1'b0, "R9 msb-first");
        t_serial(1'b1, "R9 lsb-first");
        t_ovf();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule